// File: doc/BRIEF.md
# OTP Program-and-Verify Sequencer

This block drives the control, address and data lines of a one-time-programmable byte memory to burn a block of bytes into it. For every address, starting at zero and counting up, it presents the wanted byte, fires a timed write strobe with the programming voltage switched on, then turns the data bus around and reads the byte back. If the read-back differs, it repeats the strobe-and-read loop, up to a fixed number of strobes. No extra strobe is added once a byte reads back correctly. Every delay on the memory side is counted in clock cycles from a clock-frequency parameter, using one shared down-counter.

When the last byte has been written, the programming voltage is switched off. Every byte is then read in plain read mode and compared with its source value, once at a high supply level and once at a low one. A clean pass raises `done`. Any unrecoverable mismatch raises `fail` and latches the failing address. The byte source is a plain input that must present the wanted value for whatever address is currently on `mem_addr`. The two analog rails are selected by `vpp_en` and `vcc_sel`; the block does not generate them.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, and after every run that ends in done or fail, the memory-side outputs are inactive: `mem_ce_n`=1, `mem_oe_n`=1, `mem_wdata_oe`=0, `vpp_en`=0 and `vcc_sel`=0 (nominal level).
- R2: Each write strobe holds `mem_ce_n` low for exactly PULSE_US*CLK_MHZ cycles. During the strobe, `vpp_en`=1, `mem_oe_n`=1, `mem_wdata_oe`=1 and `vcc_sel`=1 (programming level).
- R3: Address and data are driven and unchanged for at least SETUP_US*CLK_MHZ cycles before `mem_ce_n` falls in programming.
- R4: Data and address stay driven and unchanged for at least HOLD_US*CLK_MHZ cycles after a strobe ends.
- R5: `mem_wdata_oe` drops at least HOLD_US*CLK_MHZ cycles before `mem_oe_n` falls for a verify. `mem_oe_n` is never low while `mem_wdata_oe` is high.
- R6: A verify read drives `mem_oe_n` low with `mem_ce_n` high and `vpp_en` still high.
- R7: A byte is strobed until its read-back matches, at most MAX_PULSES times. A byte that still differs after MAX_PULSES strobes ends the run in fail, with `fail_addr` set to that byte's address.
- R8: A source byte equal to all ones receives no strobe. It is only verified.
- R9: Only 1→0 changes can be programmed. If a verify finds a 0 where the source wants a 1, the run fails at once, with no further strobes.
- R10: Bytes are programmed in ascending address order, 0 to NUM_BYTES-1. Each byte completes before the next one starts.
- R11: After programming, `vpp_en` is 0 and every byte is read with `mem_ce_n` and `mem_oe_n` both low, in ascending order. This pass runs first at `vcc_sel`=2 (high check level) and then at `vcc_sel`=3 (low check level).
- R12: A mismatch in the final pass raises `fail` and latches the address in `fail_addr`. A clean final pass raises `done`. The two flags are never high together.
- R13: `start` seen while idle clears `done`, `fail` and `fail_addr` and begins a new run. The flags stay set until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| src_byte | input | DATA_W | Wanted value for the address on `mem_addr` |
| mem_rdata | input | DATA_W | Data read back from the memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Data to program |
| mem_wdata_oe | output | 1 | Drive enable for `mem_wdata` |
| mem_ce_n | output | 1 | Chip enable, active low (write strobe in programming) |
| mem_oe_n | output | 1 | Output enable, active low |
| vpp_en | output | 1 | Switch the programming voltage on |
| vcc_sel | output | 2 | Supply level: 0 nominal, 1 programming, 2 high check, 3 low check |
| done | output | 1 | Run finished cleanly (sticky) |
| fail | output | 1 | Run aborted on a mismatch (sticky) |
| fail_addr | output | ADDR_W | Address of the failing byte |

## Verification
A corrupted strobe counter shows up at the ports as a wrong number of `mem_ce_n` low periods at one address. This can be seen as soon as that byte's verify decision is made, because the memory model in the bench only takes data after a set number of strobes. A wrong delay count shifts a `mem_ce_n` or `mem_oe_n` edge relative to the data enable, and the edge monitors catch it on that same transition. A wrong address or supply-level state appears in the final pass as an out-of-order read or a wrong `vcc_sel` on a read strobe. The cases with a weak cell and a cell zeroed in advance show whether the fail decision and the latched address come from the right check.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_LOAD,
        S_PULSE,
        S_HOLD,
        S_REL,
        S_VFY,
        S_VGAP,
        S_CSET,
        S_CRD,
        S_CGAP
    } seq_state_e;

    // supply level codes on vcc_sel
    localparam logic [1:0] VCC_NOM    = 2'd0;
    localparam logic [1:0] VCC_PROG   = 2'd1;
    localparam logic [1:0] VCC_CHK_HI = 2'd2;
    localparam logic [1:0] VCC_CHK_LO = 2'd3;

    // cycles covering a nanosecond delay, rounded up plus one margin cycle
    function automatic int ns_to_cyc(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000 + 1;
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/otp_interval_timer.sv
module otp_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/otp_byte_cmp.sv
module otp_byte_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] want,
    input  logic [DW-1:0] got,
    output logic          match,
    output logic          lost_one
);

    always_comb begin
        match    = (want == got);
        // a bit reads 0 that must stay 1: further pulses cannot repair it
        lost_one = |(want & ~got);
    end

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 50,
    parameter int ADDR_W     = 4,
    parameter int NUM_BYTES  = 16,
    parameter int DATA_W     = 8,
    parameter int PULSE_US   = 100,
    parameter int SETUP_US   = 2,
    parameter int HOLD_US    = 2,
    parameter int MAX_PULSES = 25,
    parameter int RD_NS      = 100,
    parameter int FLT_NS     = 130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] src_byte,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              vpp_en,
    output logic [1:0]        vcc_sel,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);

    localparam int SETUP_CYC = SETUP_US * CLK_MHZ;
    localparam int HOLD_CYC  = HOLD_US * CLK_MHZ;
    localparam int PULSE_CYC = PULSE_US * CLK_MHZ;
    localparam int RD_CYC    = ns_to_cyc(RD_NS, CLK_MHZ);
    localparam int FLT_CYC   = ns_to_cyc(FLT_NS, CLK_MHZ);
    localparam int MAX_CYC   = max_i(max_i(max_i(SETUP_CYC, HOLD_CYC), max_i(PULSE_CYC, RD_CYC)), FLT_CYC);
    localparam int TMR_W     = $clog2(MAX_CYC + 1);
    localparam int CNT_W     = $clog2(MAX_PULSES + 1);

    localparam logic [TMR_W-1:0]  T_SETUP = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0]  T_HOLD  = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0]  T_PULSE = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0]  T_RD    = TMR_W'(RD_CYC - 1);
    localparam logic [TMR_W-1:0]  T_FLT   = TMR_W'(FLT_CYC - 1);
    localparam logic [TMR_W-1:0]  T_ONE   = '0;
    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(NUM_BYTES - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(MAX_PULSES);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              woe;
        logic              ce_n;
        logic              oe_n;
        logic              vpp;
        logic [1:0]        vcc;
        logic [CNT_W-1:0]  cnt;
        logic              match;
        logic              lost;
        logic              done;
        logic              fail;
        logic [ADDR_W-1:0] fail_addr;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tmr_ld;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             cmp_match;
    logic             cmp_lost;

    otp_interval_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    otp_byte_cmp #(.DW(DATA_W)) u_cmp (
        .want     (src_byte),
        .got      (mem_rdata),
        .match    (cmp_match),
        .lost_one (cmp_lost)
    );

    always_comb begin
        r_d     = r_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.done      = 1'b0;
                    r_d.fail      = 1'b0;
                    r_d.fail_addr = '0;
                    r_d.addr      = '0;
                    r_d.cnt       = '0;
                    r_d.vpp       = 1'b1;
                    r_d.vcc       = VCC_PROG;
                    r_d.st        = S_ADDR;
                    tmr_ld        = 1'b1;
                    tmr_val       = T_SETUP;
                end
            end
            S_ADDR: begin
                if (tmr_zero) begin
                    tmr_ld = 1'b1;
                    if (src_byte == '1) begin
                        r_d.oe_n = 1'b0;
                        r_d.st   = S_VFY;
                        tmr_val  = T_RD;
                    end else begin
                        r_d.wdata = src_byte;
                        r_d.woe   = 1'b1;
                        r_d.st    = S_LOAD;
                        tmr_val   = T_SETUP;
                    end
                end
            end
            S_LOAD: begin
                if (tmr_zero) begin
                    r_d.ce_n = 1'b0;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.st   = S_PULSE;
                    tmr_ld   = 1'b1;
                    tmr_val  = T_PULSE;
                end
            end
            S_PULSE: begin
                if (tmr_zero) begin
                    r_d.ce_n = 1'b1;
                    r_d.st   = S_HOLD;
                    tmr_ld   = 1'b1;
                    tmr_val  = T_HOLD;
                end
            end
            S_HOLD: begin
                if (tmr_zero) begin
                    r_d.woe = 1'b0;
                    r_d.st  = S_REL;
                    tmr_ld  = 1'b1;
                    tmr_val = T_HOLD;
                end
            end
            S_REL: begin
                if (tmr_zero) begin
                    r_d.oe_n = 1'b0;
                    r_d.st   = S_VFY;
                    tmr_ld   = 1'b1;
                    tmr_val  = T_RD;
                end
            end
            S_VFY: begin
                if (tmr_zero) begin
                    r_d.match = cmp_match;
                    r_d.lost  = cmp_lost;
                    r_d.oe_n  = 1'b1;
                    r_d.st    = S_VGAP;
                    tmr_ld    = 1'b1;
                    tmr_val   = T_FLT;
                end
            end
            S_VGAP: begin
                if (tmr_zero) begin
                    if (r_q.match) begin
                        tmr_ld = 1'b1;
                        if (r_q.addr == LAST_A) begin
                            r_d.vpp  = 1'b0;
                            r_d.vcc  = VCC_CHK_HI;
                            r_d.addr = '0;
                            r_d.st   = S_CSET;
                            tmr_val  = T_SETUP;
                        end else begin
                            r_d.addr = r_q.addr + 1'b1;
                            r_d.cnt  = '0;
                            r_d.st   = S_ADDR;
                            tmr_val  = T_ONE;
                        end
                    end else if (r_q.lost || (r_q.cnt == CNT_MAX)) begin
                        r_d.fail      = 1'b1;
                        r_d.fail_addr = r_q.addr;
                        r_d.vpp       = 1'b0;
                        r_d.vcc       = VCC_NOM;
                        r_d.st        = S_IDLE;
                    end else begin
                        r_d.wdata = src_byte;
                        r_d.woe   = 1'b1;
                        r_d.st    = S_LOAD;
                        tmr_ld    = 1'b1;
                        tmr_val   = T_SETUP;
                    end
                end
            end
            S_CSET: begin
                if (tmr_zero) begin
                    r_d.ce_n = 1'b0;
                    r_d.oe_n = 1'b0;
                    r_d.st   = S_CRD;
                    tmr_ld   = 1'b1;
                    tmr_val  = T_RD;
                end
            end
            S_CRD: begin
                if (tmr_zero) begin
                    r_d.match = cmp_match;
                    r_d.ce_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.st    = S_CGAP;
                    tmr_ld    = 1'b1;
                    tmr_val   = T_FLT;
                end
            end
            S_CGAP: begin
                if (tmr_zero) begin
                    if (!r_q.match) begin
                        r_d.fail      = 1'b1;
                        r_d.fail_addr = r_q.addr;
                        r_d.vcc       = VCC_NOM;
                        r_d.st        = S_IDLE;
                    end else if (r_q.addr == LAST_A) begin
                        if (r_q.vcc == VCC_CHK_HI) begin
                            r_d.vcc  = VCC_CHK_LO;
                            r_d.addr = '0;
                            r_d.st   = S_CSET;
                            tmr_ld   = 1'b1;
                            tmr_val  = T_SETUP;
                        end else begin
                            r_d.done = 1'b1;
                            r_d.vcc  = VCC_NOM;
                            r_d.st   = S_IDLE;
                        end
                    end else begin
                        r_d.addr = r_q.addr + 1'b1;
                        r_d.st   = S_CSET;
                        tmr_ld   = 1'b1;
                        tmr_val  = T_ONE;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= S_IDLE;
            r_q.addr      <= '0;
            r_q.wdata     <= '0;
            r_q.woe       <= 1'b0;
            r_q.ce_n      <= 1'b1;
            r_q.oe_n      <= 1'b1;
            r_q.vpp       <= 1'b0;
            r_q.vcc       <= VCC_NOM;
            r_q.cnt       <= '0;
            r_q.match     <= 1'b0;
            r_q.lost      <= 1'b0;
            r_q.done      <= 1'b0;
            r_q.fail      <= 1'b0;
            r_q.fail_addr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr     = r_q.addr;
    assign mem_wdata    = r_q.wdata;
    assign mem_wdata_oe = r_q.woe;
    assign mem_ce_n     = r_q.ce_n;
    assign mem_oe_n     = r_q.oe_n;
    assign vpp_en       = r_q.vpp;
    assign vcc_sel      = r_q.vcc;
    assign done         = r_q.done;
    assign fail         = r_q.fail;
    assign fail_addr    = r_q.fail_addr;

endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk
    import otp_seq_pkg::*;
#(
    parameter int CLK_MHZ  = 50,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int PULSE_US = 100,
    parameter int SETUP_US = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_wdata_oe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              vpp_en,
    input logic [1:0]        vcc_sel,
    input logic              done,
    input logic              fail
);

    localparam int PULSE_CYC = PULSE_US * CLK_MHZ;
    localparam int SETUP_CYC = SETUP_US * CLK_MHZ;

    logic [ADDR_W-1:0] last_addr_q;
    logic [DATA_W-1:0] last_data_q;
    int                run_q;
    int                low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr_q <= '0;
            last_data_q <= '0;
            run_q       <= 0;
            low_q       <= 0;
        end else begin
            last_addr_q <= mem_addr;
            last_data_q <= mem_wdata;
            run_q <= (mem_wdata_oe && vpp_en && mem_addr == last_addr_q &&
                      mem_wdata == last_data_q && run_q < 1000000) ? run_q + 1 : 0;
            low_q <= (!mem_ce_n && vpp_en) ? low_q + 1 : 0;
        end
    end

    p_idle_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> (mem_ce_n && mem_oe_n && !vpp_en && !mem_wdata_oe && vcc_sel == VCC_NOM))
        else $error("p_idle_flags_r1");

    p_pulse_ctx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && vpp_en) |-> (mem_oe_n && mem_wdata_oe && vcc_sel == VCC_PROG))
        else $error("p_pulse_ctx_r2");

    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n) && vpp_en) |-> (low_q == PULSE_CYC))
        else $error("p_pulse_width_r2");

    p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && vpp_en) |-> (run_q >= SETUP_CYC - 1))
        else $error("p_setup_r3");

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_en && mem_wdata_oe && $past(mem_wdata_oe)) |-> ($stable(mem_wdata) && $stable(mem_addr)))
        else $error("p_hold_r4");

    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && mem_wdata_oe))
        else $error("p_no_contention_r5");

    p_verify_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && vpp_en) |-> mem_ce_n)
        else $error("p_verify_ctx_r6");

    p_check_supply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_sel == VCC_CHK_HI || vcc_sel == VCC_CHK_LO) |-> (!vpp_en && !mem_wdata_oe))
        else $error("p_check_supply_r11");

    p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail))
        else $error("p_flags_excl_r12");

endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .CLK_MHZ  (CLK_MHZ),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PULSE_US (PULSE_US),
    .SETUP_US (SETUP_US)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_wdata_oe (mem_wdata_oe),
    .mem_ce_n     (mem_ce_n),
    .mem_oe_n     (mem_oe_n),
    .vpp_en       (vpp_en),
    .vcc_sel      (vcc_sel),
    .done         (done),
    .fail         (fail)
);

// File: tb/otp_prog_seq_test.sv
module otp_prog_seq_test;

    localparam int CLK_MHZ   = 2;
    localparam int ADDR_W    = 2;
    localparam int NB        = 4;
    localparam int PULSE_US  = 3;
    localparam int SETUP_US  = 2;
    localparam int HOLD_US   = 2;
    localparam int MAXP      = 25;
    localparam int PULSE_CYC = PULSE_US * CLK_MHZ;
    localparam int SETUP_CYC = SETUP_US * CLK_MHZ;
    localparam int HOLD_CYC  = HOLD_US * CLK_MHZ;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [7:0]        src_byte;
    logic [7:0]        mem_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              mem_wdata_oe;
    logic              mem_ce_n;
    logic              mem_oe_n;
    logic              vpp_en;
    logic [1:0]        vcc_sel;
    logic              done;
    logic              fail;
    logic [ADDR_W-1:0] fail_addr;

    always #2 clk = ~clk;

    otp_prog_seq #(
        .CLK_MHZ    (CLK_MHZ),
        .ADDR_W     (ADDR_W),
        .NUM_BYTES  (NB),
        .DATA_W     (8),
        .PULSE_US   (PULSE_US),
        .SETUP_US   (SETUP_US),
        .HOLD_US    (HOLD_US),
        .MAX_PULSES (MAXP),
        .RD_NS      (100),
        .FLT_NS     (130)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .src_byte     (src_byte),
        .mem_rdata    (mem_rdata),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe),
        .mem_ce_n     (mem_ce_n),
        .mem_oe_n     (mem_oe_n),
        .vpp_en       (vpp_en),
        .vcc_sel      (vcc_sel),
        .done         (done),
        .fail         (fail),
        .fail_addr    (fail_addr)
    );

    int checks = 0;
    int errors = 0;

    // memory model: a byte takes its data only after need[] strobes
    logic [7:0] src   [NB];
    logic [7:0] cells [NB];
    int         need  [NB];
    int         pulses[NB];
    int         weak_addr;

    assign src_byte  = src[mem_addr];
    assign mem_rdata = !mem_oe_n ?
        (cells[mem_addr] ^ ((vcc_sel == 2'd3 && int'(mem_addr) == weak_addr) ? 8'h01 : 8'h00)) : 8'h00;

    // edge monitors
    logic       prev_ce = 1'b1, prev_oe = 1'b1, prev_woe = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [7:0] prev_wdata = '0;
    int low_cnt, stable_cnt, since_rise, rel_cnt;
    int bad_width, bad_setup, bad_hold, bad_rel, bad_conflict, bad_vfy, bad_order;
    int last_vfy_addr, reads;
    int read_addr[16];
    int read_lvl [16];

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n && mem_wdata_oe) bad_conflict++;
            if (!mem_oe_n && vpp_en && !mem_ce_n) bad_vfy++;
            // strobe start: setup window
            if (vpp_en && prev_ce && !mem_ce_n && stable_cnt < SETUP_CYC) bad_setup++;
            // strobe end: width and memory update
            if (vpp_en && !prev_ce && mem_ce_n) begin
                if (low_cnt != PULSE_CYC) bad_width++;
                pulses[mem_addr]++;
                if (pulses[mem_addr] >= need[mem_addr]) cells[mem_addr] = cells[mem_addr] & mem_wdata;
            end
            // data release
            if (prev_woe && !mem_wdata_oe && since_rise < HOLD_CYC) bad_hold++;
            if (mem_wdata_oe && prev_woe && (mem_wdata != prev_wdata || mem_addr != prev_addr)) bad_hold++;
            // output enable falls
            if (prev_oe && !mem_oe_n) begin
                if (vpp_en) begin
                    if (rel_cnt < HOLD_CYC) bad_rel++;
                    if (int'(mem_addr) < last_vfy_addr) bad_order++;
                    last_vfy_addr = int'(mem_addr);
                end else if (reads < 16) begin
                    read_addr[reads] = int'(mem_addr);
                    read_lvl[reads]  = int'(vcc_sel);
                    reads++;
                end
            end
            // counter updates
            low_cnt = (vpp_en && !mem_ce_n) ? low_cnt + 1 : 0;
            if (mem_wdata_oe && vpp_en && prev_woe && mem_wdata == prev_wdata && mem_addr == prev_addr)
                stable_cnt++;
            else
                stable_cnt = (mem_wdata_oe && vpp_en) ? 1 : 0;
            if (vpp_en && !prev_ce && mem_ce_n) since_rise = 1;
            else if (since_rise > 0 && since_rise < 1000) since_rise++;
            rel_cnt = mem_wdata_oe ? 0 : ((rel_cnt < 1000) ? rel_cnt + 1 : rel_cnt);
        end
        prev_ce    = mem_ce_n;
        prev_oe    = mem_oe_n;
        prev_woe   = mem_wdata_oe;
        prev_addr  = mem_addr;
        prev_wdata = mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic prep();
        for (int i = 0; i < NB; i++) begin
            cells[i]  = 8'hFF;
            need[i]   = 1;
            pulses[i] = 0;
        end
        src[0] = 8'hA5; src[1] = 8'hFF; src[2] = 8'h00; src[3] = 8'h3C;
        weak_addr     = -1;
        bad_width     = 0; bad_setup = 0; bad_hold = 0; bad_rel = 0;
        bad_conflict  = 0; bad_vfy = 0; bad_order = 0;
        last_vfy_addr = 0; reads = 0;
    endtask

    task automatic run();
        int cyc;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!done && !fail, "R13", "flags cleared by start", int'({done, fail}), 0);
        cyc = 0;
        while (!(done || fail) && cyc < 30000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 30000, "R12", "run ends", cyc, 0);
        @(negedge clk);
    endtask

    task automatic chk_idle(input string tag);
        chk(mem_ce_n && mem_oe_n && !mem_wdata_oe && !vpp_en && vcc_sel == 2'd0, "R1", tag,
            int'({mem_ce_n, mem_oe_n, mem_wdata_oe, vpp_en, vcc_sel}), 6'b110000);
    endtask

    task automatic chk_timing();
        chk(bad_width == 0, "R2", "strobe width errors", bad_width, 0);
        chk(bad_setup == 0, "R3", "setup errors", bad_setup, 0);
        chk(bad_hold == 0, "R4", "hold errors", bad_hold, 0);
        chk(bad_rel == 0 && bad_conflict == 0, "R5", "release/contention errors", bad_rel + bad_conflict, 0);
        chk(bad_vfy == 0, "R6", "verify with chip enable low", bad_vfy, 0);
        chk(bad_order == 0, "R10", "verify address order", bad_order, 0);
    endtask

    initial begin
        #(4 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        prep();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("reset state");
        chk(!done && !fail, "R1", "flags after reset", int'({done, fail}), 0);

        // A: clean run, 25-strobe boundary at address 3
        prep();
        need[2] = 3; need[3] = MAXP;
        run();
        chk(done && !fail, "R12", "clean run done", int'({done, fail}), 2);
        chk(pulses[0] == 1, "R7", "strobes addr0", pulses[0], 1);
        chk(pulses[1] == 0, "R8", "strobes on all-ones byte", pulses[1], 0);
        chk(pulses[2] == 3, "R7", "strobes addr2", pulses[2], 3);
        chk(pulses[3] == MAXP, "R7", "strobes at limit", pulses[3], MAXP);
        for (int i = 0; i < NB; i++)
            chk(cells[i] == src[i], "R10", "programmed content", int'(cells[i]), int'(src[i]));
        chk(reads == 2 * NB, "R11", "final read count", reads, 2 * NB);
        for (int k = 0; k < 2 * NB; k++) begin
            chk(read_addr[k] == k % NB, "R11", "final read address", read_addr[k], k % NB);
            chk(read_lvl[k] == 2 + k / NB, "R11", "final read level", read_lvl[k], 2 + k / NB);
        end
        chk_timing();
        chk_idle("idle after done");

        // B: one byte needs one strobe beyond the limit
        prep();
        need[2] = MAXP + 1;
        run();
        chk(fail && !done, "R7", "fail over limit", int'({done, fail}), 1);
        chk(int'(fail_addr) == 2, "R7", "fail address", int'(fail_addr), 2);
        chk(pulses[2] == MAXP, "R7", "strobes before fail", pulses[2], MAXP);
        chk(pulses[3] == 0, "R10", "no later byte touched", pulses[3], 0);
        chk(reads == 0, "R11", "no final pass after fail", reads, 0);
        chk_timing();
        chk_idle("idle after fail");

        // C: all-ones source over a cell already zeroed
        prep();
        cells[1] = 8'hF7;
        run();
        chk(fail && int'(fail_addr) == 1, "R8", "all-ones verify fails", int'(fail_addr), 1);
        chk(pulses[1] == 0, "R8", "no strobe on all-ones", pulses[1], 0);
        chk(pulses[0] == 1, "R10", "previous byte strobes", pulses[0], 1);

        // D: a wanted 1 reads as 0 after the first strobe
        prep();
        cells[0] = 8'h7F;
        need[0]  = 1;
        run();
        chk(fail && int'(fail_addr) == 0, "R9", "lost one fail address", int'(fail_addr), 0);
        chk(pulses[0] == 1, "R9", "no retry after lost one", pulses[0], 1);

        // E: byte 3 reads wrong only at the low check level
        prep();
        weak_addr = 3;
        run();
        chk(fail && !done, "R12", "final pass fail", int'({done, fail}), 1);
        chk(int'(fail_addr) == 3, "R12", "final pass fail address", int'(fail_addr), 3);
        chk(reads == 2 * NB, "R11", "reads up to failing byte", reads, 2 * NB);
        chk(read_lvl[2 * NB - 1] == 3, "R11", "failing read at low level", read_lvl[2 * NB - 1], 3);
        chk_idle("idle after final fail");

        // F: restart after a fail
        prep();
        run();
        chk(done && !fail, "R13", "restart clean", int'({done, fail}), 2);
        chk(int'(fail_addr) == 0, "R13", "fail address cleared", int'(fail_addr), 0);
        chk_timing();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule